// File: doc/BRIEF.md
# Interrupt Claim/Complete Arbiter Core

This block is the central arbitration stage of a platform-level interrupt controller. It keeps a small priority value and a pending flag for every interrupt source. For each target context it also keeps a set of enable bits and a priority threshold. Gateways in front of it deliver one-cycle request pulses, one bit per source ID. The block drives one external-interrupt line per context. The line is raised whenever that context has a pending, enabled source whose priority is above the context's threshold.

Software reaches the block through a word-addressed register port with byte offsets. Reading a context's claim/complete word returns the best eligible source for that context and clears the source's pending flag in the same cycle. Writing a source ID to that word sends a one-cycle completion pulse back towards the gateways, provided the ID is currently enabled for the writing context. Source ID 0 is reserved and means "no interrupt".

Top module: `irq_arbiter_core`

## Requirements
- R1: After reset, all priorities, pending flags, enable bits and thresholds are zero, every `eip` bit is low, and every mapped register reads 0.
- R2: The priority of source n is a 3-bit register at byte offset 4*n. Only the low 3 bits of a write are kept. The word for ID 0 always reads 0 and ignores writes.
- R3: A request pulse on `srcReq[n]` sets pending flag n. Pending flags read as bit n%32 of the word at 0x1000 + 4*(n/32), whatever the enable settings. Writes to the pending words have no effect.
- R4: The enable bits of context c are packed 32 per word at 0x2000 + 0x80*c + 4*w, with bit b standing for source 32*w + b. Bit 0 and bits above the last source read 0.
- R5: `eip[c]` is high, starting in the cycle after the edge that changes the state, exactly when some source that is pending and enabled for c has a priority strictly greater than the threshold of c.
- R6: Among the eligible sources, the one with the highest priority is selected, and ties go to the lowest ID. A source with priority 0 is never selected.
- R7: A read of 0x200004 + 0x1000*c returns the ID selected for c, even when its priority does not exceed the threshold, and clears that source's pending flag at the same edge. If no source is eligible, the read returns 0 and changes nothing.
- R8: A write of ID n to 0x200004 + 0x1000*c that n is enabled for c raises `cmpValid` for one cycle, in the cycle after the write edge, with `cmpId` = n. The ID is not compared with any earlier claim. IDs that are not enabled for c, ID 0 and IDs out of range produce no pulse.
- R9: When a request for a source and a claim of that same source fall on the same edge, the pending flag stays set.
- R10: The threshold of context c is a 3-bit register at 0x200000 + 0x1000*c that keeps only the low 3 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC | Request pulses from the gateways, bit n = source n |
| regAddr | input | ADDR_W | Byte address of the register access (word aligned) |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe; a claim read has its side effect at this edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid combinationally while `regRdEn` is high |
| eip | output | NUM_CTX | External-interrupt line per context |
| cmpValid | output | 1 | One-cycle completion pulse towards the gateways |
| cmpId | output | ID_W | Source ID of the completion |

## Verification
Read data comes straight from the current state during the read cycle. The bench therefore samples `regRdData` shortly after the falling edge at which the read is driven, before the clock edge that applies any claim. Pending flags, enables, priorities and thresholds change at the edge that takes the pulse or the write, and `eip` is decoded from them without another register. So `eip` and the pending words are checked at the first falling edge after that edge. `cmpValid` is registered once, and the bench reads it at the falling edge that follows the write edge, then again one cycle later to see it drop.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

  // which register the read-data mux presents
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } rdSel_e;

  // strobes from the decoder to the state datapath
  typedef struct packed {
    logic        prioWe;
    logic        enWe;
    logic        thrWe;
    logic        claimRd;
    logic        compWr;
    rdSel_e      rdSel;
    logic [9:0]  idx;    // source index for priority access
    logic [4:0]  word;   // word index for pending/enable access
    logic [7:0]  ctx;    // context index
    logic [31:0] wdata;
  } strobe_t;

endpackage

// File: rtl/irq_arb_ctrl.sv
`timescale 1ns/1ps
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24   // must be at least 22
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [31:0]       regWrData,
  output strobe_t           strb
);
  localparam int WORDS = (NUM_SRC + 31) / 32;

  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] CTX_BASE  = ADDR_W'(32'h200000);

  logic [ADDR_W-1:0] off;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    strb.wdata = regWrData;
    off        = '0;
    if (regAddr < PEND_BASE) begin
      strb.idx = regAddr[11:2];
      if (32'(regAddr[11:2]) < NUM_SRC) begin
        strb.prioWe = regWrEn;
        if (regRdEn) strb.rdSel = SEL_PRIO;
      end
    end else if (regAddr < EN_BASE) begin
      strb.word = regAddr[6:2];
      if (32'(regAddr[11:2]) < WORDS) begin
        if (regRdEn) strb.rdSel = SEL_PEND;
      end
    end else if (regAddr < CTX_BASE) begin
      off       = regAddr - EN_BASE;
      strb.word = off[6:2];
      strb.ctx  = 8'(off >> 7);
      if ((off >> 7) < ADDR_W'(NUM_CTX) && 32'(off[6:2]) < WORDS) begin
        strb.enWe = regWrEn;
        if (regRdEn) strb.rdSel = SEL_EN;
      end
    end else begin
      off      = regAddr - CTX_BASE;
      strb.ctx = 8'(off >> 12);
      if ((off >> 12) < ADDR_W'(NUM_CTX)) begin
        if (off[11:2] == 10'd0) begin
          strb.thrWe = regWrEn;
          if (regRdEn) strb.rdSel = SEL_THR;
        end else if (off[11:2] == 10'd1) begin
          strb.claimRd = regRdEn;
          strb.compWr  = regWrEn;
          if (regRdEn) strb.rdSel = SEL_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/irq_arb_select.sv
`timescale 1ns/1ps
module irq_arb_select #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [ID_W-1:0]           bestId,
  output logic [PRIO_W-1:0]         bestPrio
);
  // strict comparison while scanning upwards keeps the lowest ID on ties;
  // starting from priority 0 excludes priority-0 sources
  always_comb begin
    bestId   = '0;
    bestPrio = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig[i] && prioFlat[i*PRIO_W +: PRIO_W] > bestPrio) begin
        bestId   = ID_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/irq_arb_datapath.sv
`timescale 1ns/1ps
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcReq,
  input  strobe_t                   strb,
  output logic [31:0]               rdData,
  output logic [NUM_CTX-1:0]        eip,
  output logic                      cmpValid,
  output logic [ID_W-1:0]           cmpId,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [NUM_CTX*ID_W-1:0]   bestIdFlat,
  output logic [NUM_CTX*PRIO_W-1:0] bestPrioFlat
);
  localparam int WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W = WORDS * 32;

  logic [PRIO_W-1:0]         prio [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [NUM_SRC-1:0]        pend;
  logic [NUM_SRC-1:0]        en   [NUM_CTX];
  logic [PRIO_W-1:0]         thr  [NUM_CTX];
  logic [ID_W-1:0]           bestId   [NUM_CTX];
  logic [PRIO_W-1:0]         bestPrio [NUM_CTX];
  logic [NUM_SRC-1:0]        clrVec;
  logic                      compHit;
  logic [PAD_W-1:0]          pendPad;
  logic [PAD_W-1:0]          enPad [NUM_CTX];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
    assign prioFlat[i*PRIO_W +: PRIO_W] = prio[i];
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_arb_select #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) uSel (
      .elig    (pend & en[c]),
      .prioFlat(prioFlat),
      .bestId  (bestId[c]),
      .bestPrio(bestPrio[c])
    );
    assign eip[c]                             = bestPrio[c] > thr[c];
    assign enPad[c]                           = PAD_W'(en[c]);
    assign bestIdFlat[c*ID_W +: ID_W]         = bestId[c];
    assign bestPrioFlat[c*PRIO_W +: PRIO_W]   = bestPrio[c];
  end

  assign pendPad = PAD_W'(pend);
  assign pendVec = pend;

  // pending flag cleared by a claim of the addressed context
  always_comb begin
    clrVec = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (strb.claimRd && strb.ctx == 8'(c)) begin
        for (int i = 1; i < NUM_SRC; i++) begin
          if (bestId[c] == ID_W'(i)) clrVec[i] = 1'b1;
        end
      end
    end
  end

  // completion accepted only for an ID enabled in the writing context
  always_comb begin
    compHit = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int i = 1; i < NUM_SRC; i++) begin
        if (strb.ctx == 8'(c) && strb.wdata == 32'(i) && en[c][i]) compHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= '0;
      cmpValid <= 1'b0;
      cmpId    <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      pend     <= ((pend & ~clrVec) | srcReq) & ~NUM_SRC'(1);
      cmpValid <= strb.compWr && compHit;
      cmpId    <= strb.wdata[ID_W-1:0];
      for (int i = 1; i < NUM_SRC; i++) begin
        if (strb.prioWe && strb.idx == 10'(i)) prio[i] <= strb.wdata[PRIO_W-1:0];
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (strb.thrWe && strb.ctx == 8'(c)) thr[c] <= strb.wdata[PRIO_W-1:0];
        for (int w = 0; w < WORDS; w++) begin
          if (strb.enWe && strb.ctx == 8'(c) && strb.word == 5'(w)) begin
            for (int b = 0; b < 32; b++) begin
              if (w*32 + b < NUM_SRC && w*32 + b != 0) en[c][w*32 + b] <= strb.wdata[b];
            end
          end
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_PRIO: begin
        for (int i = 1; i < NUM_SRC; i++)
          if (strb.idx == 10'(i)) rdData = 32'(prio[i]);
      end
      SEL_PEND: begin
        for (int w = 0; w < WORDS; w++)
          if (strb.word == 5'(w)) rdData = pendPad[w*32 +: 32];
      end
      SEL_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          for (int w = 0; w < WORDS; w++)
            if (strb.ctx == 8'(c) && strb.word == 5'(w)) rdData = enPad[c][w*32 +: 32];
      end
      SEL_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (strb.ctx == 8'(c)) rdData = 32'(thr[c]);
      end
      SEL_CLAIM: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (strb.ctx == 8'(c)) rdData = 32'(bestId[c]);
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_arbiter_core.sv
`timescale 1ns/1ps
module irq_arbiter_core
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic [NUM_CTX-1:0] eip,
  output logic               cmpValid,
  output logic [ID_W-1:0]    cmpId
);
  strobe_t                   strb;
  logic [NUM_SRC-1:0]        pendVec;
  logic [NUM_CTX*ID_W-1:0]   bestIdFlat;
  logic [NUM_CTX*PRIO_W-1:0] bestPrioFlat;

  irq_arb_ctrl #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)
  ) uCtrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData),
    .strb     (strb)
  );

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .srcReq      (srcReq),
    .strb        (strb),
    .rdData      (regRdData),
    .eip         (eip),
    .cmpValid    (cmpValid),
    .cmpId       (cmpId),
    .pendVec     (pendVec),
    .bestIdFlat  (bestIdFlat),
    .bestPrioFlat(bestPrioFlat)
  );

endmodule

// File: rtl/irq_arb_chk.sv
`timescale 1ns/1ps
module irq_arb_chk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_SRC-1:0]        srcReq,
  input logic [NUM_SRC-1:0]        pendVec,
  input logic [NUM_CTX-1:0]        eip,
  input logic                      cmpValid,
  input logic                      regWrEn,
  input logic                      regRdEn,
  input logic [NUM_CTX*ID_W-1:0]   bestIdFlat,
  input logic [NUM_CTX*PRIO_W-1:0] bestPrioFlat
);
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    // R3: a pending flag only rises after a request pulse
    p_pend_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendVec[i]) |-> $past(srcReq[i]));
    // R7: a pending flag only falls after a read (claim)
    p_pend_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[i]) |-> $past(regRdEn));
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    // R5: an asserted line always has a selectable source behind it
    p_eip_source_r5: assert property (@(posedge clk) disable iff (!rstN)
      eip[c] |-> bestIdFlat[c*ID_W +: ID_W] != '0);
    // R6: a selected source never has priority zero
    p_prio_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
      bestIdFlat[c*ID_W +: ID_W] != '0 |-> bestPrioFlat[c*PRIO_W +: PRIO_W] != '0);
  end

  // R8: a completion pulse is caused by a write one cycle earlier
  p_cmp_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> $past(regWrEn));

endmodule

bind irq_arbiter_core irq_arb_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ID_W(ID_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .srcReq      (srcReq),
  .pendVec     (pendVec),
  .eip         (eip),
  .cmpValid    (cmpValid),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .bestIdFlat  (bestIdFlat),
  .bestPrioFlat(bestPrioFlat)
);

// File: tb/tb_irq_arbiter_core.sv
`timescale 1ns/1ps
module tb_irq_arbiter_core;
  localparam int NUM_SRC = 40;
  localparam int NUM_CTX = 2;
  localparam int ADDR_W  = 24;
  localparam int ID_W    = $clog2(NUM_SRC);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcReq = '0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic               regWrEn = 1'b0;
  logic               regRdEn = 1'b0;
  logic [31:0]        regWrData = '0;
  logic [31:0]        regRdData;
  logic [NUM_CTX-1:0] eip;
  logic               cmpValid;
  logic [ID_W-1:0]    cmpId;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_arbiter_core #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)
  ) dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .eip(eip), .cmpValid(cmpValid), .cmpId(cmpId)
  );

  function automatic logic [ADDR_W-1:0] aPrio(int id);
    return ADDR_W'(4 * id);
  endfunction
  function automatic logic [ADDR_W-1:0] aPend(int w);
    return ADDR_W'(32'h1000 + 4 * w);
  endfunction
  function automatic logic [ADDR_W-1:0] aEn(int c, int w);
    return ADDR_W'(32'h2000 + 32'h80 * c + 4 * w);
  endfunction
  function automatic logic [ADDR_W-1:0] aThr(int c);
    return ADDR_W'(32'h200000 + 32'h1000 * c);
  endfunction
  function automatic logic [ADDR_W-1:0] aClm(int c);
    return ADDR_W'(32'h200004 + 32'h1000 * c);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] m);
    @(negedge clk);
    srcReq = m;
    @(negedge clk);
    srcReq = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 eip after reset", 32'(eip), 0);
    regRead(aPrio(5), rd);    chk("R1 prio5", rd, 0);
    regRead(aPend(0), rd);    chk("R1 pend0", rd, 0);
    regRead(aEn(1, 1), rd);   chk("R1 en c1w1", rd, 0);
    regRead(aThr(0), rd);     chk("R1 thr0", rd, 0);
    regRead(aClm(0), rd);     chk("R1 claim0", rd, 0);

    // R2 priority registers
    regWrite(aPrio(7), 5);    regRead(aPrio(7), rd); chk("R2 prio7", rd, 5);
    regWrite(aPrio(7), 32'hFF); regRead(aPrio(7), rd); chk("R2 prio7 width", rd, 7);
    regWrite(aPrio(0), 3);    regRead(aPrio(0), rd); chk("R2 prio0 fixed", rd, 0);
    regWrite(aPrio(7), 0);

    // R10 threshold width
    regWrite(aThr(1), 32'hFF); regRead(aThr(1), rd); chk("R10 thr1 width", rd, 7);
    regWrite(aThr(1), 0);

    // R4 enable packing
    regWrite(aEn(0, 0), 32'hFFFFFFFF); regRead(aEn(0, 0), rd); chk("R4 en c0w0", rd, 32'hFFFFFFFE);
    regWrite(aEn(0, 1), 32'hFFFFFFFF); regRead(aEn(0, 1), rd); chk("R4 en c0w1", rd, 32'h000000FF);
    regRead(aEn(1, 0), rd); chk("R4 en c1 untouched", rd, 0);
    regWrite(aEn(0, 0), 0); regWrite(aEn(0, 1), 0);

    // R5/R6/R7 sweep: single source 3 on context 0, every priority and threshold
    regWrite(aEn(0, 0), 32'h8);
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 8; t++) begin
        regWrite(aPrio(3), 32'(p));
        regWrite(aThr(0), 32'(t));
        pulse(NUM_SRC'(1) << 3);
        chk($sformatf("R5 eip p=%0d t=%0d", p, t), 32'(eip[0]), (p > t) ? 1 : 0);
        regRead(aPend(0), rd); chk("R3 pend visible", rd, 32'h8);
        regRead(aClm(0), rd);
        chk($sformatf("R7 claim p=%0d t=%0d", p, t), rd, (p != 0) ? 3 : 0);
        regRead(aPend(0), rd);
        chk("R7 claim clears", rd, (p != 0) ? 0 : 32'h8);
      end
    end
    regWrite(aThr(0), 0);

    // R6 simultaneous requests, priority order and ties
    regWrite(aPrio(3), 2); regWrite(aPrio(5), 4);
    regWrite(aPrio(9), 6); regWrite(aPrio(20), 6);
    regWrite(aEn(0, 0), (1 << 3) | (1 << 5) | (1 << 9) | (1 << 20));
    pulse((NUM_SRC'(1) << 3) | (NUM_SRC'(1) << 5) | (NUM_SRC'(1) << 9) | (NUM_SRC'(1) << 20));
    regRead(aPend(0), rd); chk("R3 simultaneous pend", rd, (1 << 3) | (1 << 5) | (1 << 9) | (1 << 20));
    chk("R5 eip multi", 32'(eip), 1);
    regRead(aClm(0), rd); chk("R6 tie low id", rd, 9);
    regRead(aClm(0), rd); chk("R6 second of tie", rd, 20);
    regRead(aClm(0), rd); chk("R6 next prio", rd, 5);
    regRead(aClm(0), rd); chk("R6 lowest prio", rd, 3);
    chk("R5 eip drained", 32'(eip), 0);
    regRead(aClm(0), rd); chk("R7 empty claim", rd, 0);
    regRead(aPend(0), rd); chk("R7 empty no change", rd, 0);

    // R3/R4/R5 pending without enable, per-context enable
    regWrite(aPrio(33), 5);
    pulse(NUM_SRC'(1) << 33);
    regRead(aPend(1), rd); chk("R3 pend w1 unenabled", rd, 32'h2);
    chk("R5 eip none enabled", 32'(eip), 0);
    regRead(aClm(1), rd); chk("R7 claim unenabled", rd, 0);
    regRead(aPend(1), rd); chk("R7 pend kept", rd, 32'h2);
    regWrite(aEn(1, 1), 32'h2);
    chk("R5 eip ctx1 only", 32'(eip), 2);
    regRead(aClm(1), rd); chk("R7 claim ctx1", rd, 33);
    regRead(aPend(1), rd); chk("R7 pend w1 cleared", rd, 0);

    // R8 completion
    regWrite(aClm(1), 33);
    chk("R8 cmp valid", 32'(cmpValid), 1);
    chk("R8 cmp id", 32'(cmpId), 33);
    @(negedge clk);
    chk("R8 cmp one cycle", 32'(cmpValid), 0);
    regWrite(aClm(1), 5);  chk("R8 not enabled ignored", 32'(cmpValid), 0);
    regWrite(aClm(0), 0);  chk("R8 id0 ignored", 32'(cmpValid), 0);
    regWrite(aClm(0), 50); chk("R8 out of range ignored", 32'(cmpValid), 0);
    regWrite(aClm(0), 9);  chk("R8 unclaimed id accepted", 32'(cmpValid), 1);
    regWrite(aClm(0), 9);  chk("R8 repeat accepted", 32'(cmpValid), 1);
    chk("R8 repeat id", 32'(cmpId), 9);

    // R9 request and claim on the same edge
    pulse(NUM_SRC'(1) << 5);
    @(negedge clk);
    regAddr = aClm(0); regRdEn = 1'b1; srcReq = NUM_SRC'(1) << 5;
    #1 rd = regRdData;
    chk("R9 claim returns", rd, 5);
    @(negedge clk);
    regRdEn = 1'b0; srcReq = '0;
    regRead(aPend(0), rd); chk("R9 pend stays", rd, 32'h20);
    regRead(aClm(0), rd); chk("R9 second claim", rd, 5);

    // R3 pending words ignore writes
    regWrite(aPend(0), 32'hFFFFFFFF);
    regRead(aPend(0), rd); chk("R3 pend write ignored", rd, 0);
    chk("R3 eip unchanged", 32'(eip), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule